// File: doc/BRIEF.md
# Proximity Sensor Command-Byte Register Interface

This block sits between a byte-level serial bus front end and the proximity engine of a sensor. The front end reports the start of each bus transaction, hands over every byte the host writes, and asks for a byte whenever the host reads. The first byte written after a start may be a command byte. A command byte selects a 5-bit register address and a transfer type. The type decides whether later data bytes keep hitting the same address, step through addresses one at a time, or whether the byte is a special function that acts at once and carries no data.

The block holds the configuration bytes the proximity engine uses: the enable bits, conversion and wait timing, two 16-bit interrupt thresholds, persistence, configuration bits, pulse count, gain control and offset. It drives them as plain outputs. On reads it returns those bytes, and also a fixed identity byte, a status byte built from the engine's flags, and the two bytes of the 16-bit proximity result. Reading the low result byte captures the high byte, so a 16-bit value read as two bytes is always consistent. The interrupt-clear special functions raise a single-cycle strobe toward the engine.

Top module: `prox_cmd_regif`

## Requirements
- R1: The first byte written after `bus_start` is a command when its bit 7 is 1. Bits 6:5 give the transfer type and bits 4:0 give the register address or the special code. Types 00 and 01 load both the address and the type.
- R2: A first byte with bit 7 clear, and every later byte of the transaction whatever its bit 7, is data. It is written to the held address.
- R3: With type 00 (repeat), every data write or read uses the same held address.
- R4: With type 01 (increment), the held address rises by one after each data write or read, and 0x1F is followed by 0x00.
- R5: A command of type 10 changes neither the held address nor the held type.
- R6: A command of type 11 with code 00101 or 00111 drives `int_clr` high for exactly the one cycle after the write. Any other type-11 code gives no strobe. No type-11 command changes the held address or type.
- R7: After reset PTIME (0x02) and WTIME (0x03) read 0xFF, all other writable registers read 0x00, `int_clr` and `rd_data` are 0, and the held address is 0x00 with type repeat.
- R8: Address 0x12 reads 0x39. Address 0x13 reads saturation in bit 6, interrupt pending in bit 5 and valid in bit 1, with every other bit 0.
- R9: Reading 0x18 returns the low result byte and copies the current high byte into a shadow. Reading 0x19 returns that shadow even if the result has since changed.
- R10: Unmapped addresses read 0x00. Writes to unmapped or read-only addresses have no effect.
- R11: The writable registers are 0x00 enable, 0x02 PTIME, 0x03 WTIME, 0x08/0x09 low threshold (low byte, high byte), 0x0A/0x0B high threshold, 0x0C persistence, 0x0D configuration, 0x0E pulse count, 0x0F control and 0x1E offset. Each one drives its output. Enable bit 0 is power-on, bit 2 proximity enable, bit 3 wait enable, bit 5 interrupt enable and bit 6 sleep-after-interrupt. Configuration bit 0 is reduced drive and bit 1 is long wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Transaction start seen by the front end |
| wr_stb | input | 1 | A written byte is present on `wr_byte` |
| wr_byte | input | 8 | Byte written by the host |
| rd_req | input | 1 | Host reads a byte; result on `rd_data` next cycle |
| prox_data | input | 16 | Current proximity result from the engine |
| st_sat | input | 1 | Engine saturation flag |
| st_int | input | 1 | Engine interrupt-pending flag |
| st_valid | input | 1 | Engine result-valid flag |
| rd_data | output | 8 | Read byte, registered |
| int_clr | output | 1 | One-cycle interrupt and saturation clear strobe |
| en_pon | output | 1 | Power-on enable |
| en_pen | output | 1 | Proximity enable |
| en_wen | output | 1 | Wait enable |
| en_pien | output | 1 | Proximity interrupt enable |
| en_sai | output | 1 | Sleep after interrupt |
| cfg_pdl | output | 1 | Reduced LED drive level |
| cfg_wlong | output | 1 | Long wait multiplier |
| ptime | output | 8 | Conversion time setting |
| wtime | output | 8 | Wait time setting |
| thr_lo | output | 16 | Low interrupt threshold |
| thr_hi | output | 16 | High interrupt threshold |
| pers | output | 8 | Persistence byte |
| ppulse | output | 8 | LED pulse count |
| ctrl | output | 8 | Gain and drive control byte |
| poffset | output | 8 | Proximity offset |

## Verification
The main function is exercised by byte sequences from a table. A repeat-mode command followed by two reads separates a held address from a stepping one. An increment-mode burst of four writes, read back in a second burst, shows that address stepping is the same for writes and reads, and a burst starting at 0x1F shows the wrap. Reserved-type commands, first bytes with bit 7 clear, and data bytes with bit 7 set each show whether the decoder tells commands from data by position rather than by value alone. Directed tests cover the shadowed high byte across a result change, strobing and non-strobing special codes, the status bit packing and the reset values.

// File: rtl/prox_regif_pkg.sv
package prox_regif_pkg;
  localparam int AW   = 5;
  localparam int DW   = 8;
  localparam int NREG = 1 << AW;

  typedef enum logic [1:0] {
    XFER_REPEAT = 2'b00,
    XFER_INC    = 2'b01,
    XFER_RSV    = 2'b10,
    XFER_SPEC   = 2'b11
  } xfer_e;

  localparam logic [AW-1:0] A_ENABLE  = 5'h00;
  localparam logic [AW-1:0] A_PTIME   = 5'h02;
  localparam logic [AW-1:0] A_WTIME   = 5'h03;
  localparam logic [AW-1:0] A_TLO_L   = 5'h08;
  localparam logic [AW-1:0] A_TLO_H   = 5'h09;
  localparam logic [AW-1:0] A_THI_L   = 5'h0A;
  localparam logic [AW-1:0] A_THI_H   = 5'h0B;
  localparam logic [AW-1:0] A_PERS    = 5'h0C;
  localparam logic [AW-1:0] A_CONFIG  = 5'h0D;
  localparam logic [AW-1:0] A_PPULSE  = 5'h0E;
  localparam logic [AW-1:0] A_CONTROL = 5'h0F;
  localparam logic [AW-1:0] A_ID      = 5'h12;
  localparam logic [AW-1:0] A_STATUS  = 5'h13;
  localparam logic [AW-1:0] A_RES_LO  = 5'h18;
  localparam logic [AW-1:0] A_RES_HI  = 5'h19;
  localparam logic [AW-1:0] A_OFFSET  = 5'h1E;

  // Storage exists only at these addresses
  function automatic bit reg_writable(input int a);
    case (a)
      int'(A_ENABLE), int'(A_PTIME), int'(A_WTIME), int'(A_TLO_L), int'(A_TLO_H),
      int'(A_THI_L), int'(A_THI_H), int'(A_PERS), int'(A_CONFIG), int'(A_PPULSE),
      int'(A_CONTROL), int'(A_OFFSET): return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DW-1:0] reg_reset(input int a);
    if (a == int'(A_PTIME) || a == int'(A_WTIME)) return '1;
    return '0;
  endfunction

  function automatic logic is_clear_code(input logic [AW-1:0] c);
    return (c == 5'b00101) || (c == 5'b00111);
  endfunction

  function automatic logic [DW-1:0] pack_status(input logic sat, input logic intp,
                                                input logic vld);
    logic [DW-1:0] s;
    s    = '0;
    s[6] = sat;
    s[5] = intp;
    s[1] = vld;
    return s;
  endfunction
endpackage

// File: rtl/prox_cmd_decode.sv
module prox_cmd_decode
  import prox_regif_pkg::*;
(
  input  logic [DW-1:0] byte_i,
  input  logic          first_i,
  output logic          is_cmd,
  output logic          is_data,
  output xfer_e         ctype,
  output logic [AW-1:0] code,
  output logic          set_hit,
  output logic          rsv_hit,
  output logic          clr_hit
);
  always_comb begin
    is_cmd  = first_i && byte_i[DW-1];
    is_data = !is_cmd;
    ctype   = xfer_e'(byte_i[6:5]);
    code    = byte_i[AW-1:0];
    set_hit = is_cmd && (ctype == XFER_REPEAT || ctype == XFER_INC);
    rsv_hit = is_cmd && (ctype == XFER_RSV);
    clr_hit = is_cmd && (ctype == XFER_SPEC) && is_clear_code(code);
  end
endmodule

// File: rtl/prox_reg_file.sv
module prox_reg_file
  import prox_regif_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (reg_writable(i)) begin : g_store
      logic [DW-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= reg_reset(i);
        else if (we && waddr == AW'(i)) r <= wdata;
      end
      assign q[i] = r;
    end else begin : g_none
      assign q[i] = '0;
    end
  end
endmodule

// File: rtl/prox_read_mux.sv
module prox_read_mux
  import prox_regif_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] regs [NREG],
  input  logic [2*DW-1:0] prox_data,
  input  logic          st_sat,
  input  logic          st_int,
  input  logic          st_valid,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] shadow_q;
  logic [DW-1:0] rd_val;

  always_comb begin
    case (rd_addr)
      A_ID:     rd_val = ID_VALUE;
      A_STATUS: rd_val = pack_status(st_sat, st_int, st_valid);
      A_RES_LO: rd_val = prox_data[DW-1:0];
      A_RES_HI: rd_val = shadow_q;
      default:  rd_val = regs[rd_addr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      shadow_q <= '0;
    end else if (rd_req) begin
      rd_data <= rd_val;
      if (rd_addr == A_RES_LO) shadow_q <= prox_data[2*DW-1:DW];
    end
  end

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == A_ID) |=> rd_data == ID_VALUE); // R8
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == A_RES_LO) |=> shadow_q == $past(prox_data[2*DW-1:DW])); // R9
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && rd_addr == A_RES_LO) |=> $stable(shadow_q)); // R9
endmodule

// File: rtl/prox_cmd_regif.sv
module prox_cmd_regif
  import prox_regif_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_start,
  input  logic        wr_stb,
  input  logic [7:0]  wr_byte,
  input  logic        rd_req,
  input  logic [15:0] prox_data,
  input  logic        st_sat,
  input  logic        st_int,
  input  logic        st_valid,
  output logic [7:0]  rd_data,
  output logic        int_clr,
  output logic        en_pon,
  output logic        en_pen,
  output logic        en_wen,
  output logic        en_pien,
  output logic        en_sai,
  output logic        cfg_pdl,
  output logic        cfg_wlong,
  output logic [7:0]  ptime,
  output logic [7:0]  wtime,
  output logic [15:0] thr_lo,
  output logic [15:0] thr_hi,
  output logic [7:0]  pers,
  output logic [7:0]  ppulse,
  output logic [7:0]  ctrl,
  output logic [7:0]  poffset
);
  logic          first_q;
  logic [AW-1:0] addr_q;
  xfer_e         mode_q;
  logic          int_clr_q;

  logic          dec_cmd, dec_data, dec_set, dec_rsv, dec_clr;
  xfer_e         dec_type;
  logic [AW-1:0] dec_code;
  logic          wr_data_ev, acc_ev;
  logic [DW-1:0] regs [NREG];

  prox_cmd_decode u_dec (
    .byte_i (wr_byte),
    .first_i(first_q),
    .is_cmd (dec_cmd),
    .is_data(dec_data),
    .ctype  (dec_type),
    .code   (dec_code),
    .set_hit(dec_set),
    .rsv_hit(dec_rsv),
    .clr_hit(dec_clr)
  );

  assign wr_data_ev = wr_stb && dec_data;
  assign acc_ev     = wr_data_ev || rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= 1'b0;
      addr_q    <= '0;
      mode_q    <= XFER_REPEAT;
      int_clr_q <= 1'b0;
    end else begin
      if (bus_start)   first_q <= 1'b1;
      else if (wr_stb) first_q <= 1'b0;
      if (wr_stb && dec_set) begin
        addr_q <= dec_code;
        mode_q <= dec_type;
      end else if (acc_ev && mode_q == XFER_INC) begin
        addr_q <= addr_q + 1'b1;
      end
      int_clr_q <= wr_stb && dec_clr;
    end
  end

  prox_reg_file u_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_data_ev),
    .waddr(addr_q),
    .wdata(wr_byte),
    .q    (regs)
  );

  prox_read_mux #(.ID_VALUE(ID_VALUE)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_addr  (addr_q),
    .regs     (regs),
    .prox_data(prox_data),
    .st_sat   (st_sat),
    .st_int   (st_int),
    .st_valid (st_valid),
    .rd_data  (rd_data)
  );

  assign int_clr   = int_clr_q;
  assign en_pon    = regs[A_ENABLE][0];
  assign en_pen    = regs[A_ENABLE][2];
  assign en_wen    = regs[A_ENABLE][3];
  assign en_pien   = regs[A_ENABLE][5];
  assign en_sai    = regs[A_ENABLE][6];
  assign cfg_pdl   = regs[A_CONFIG][0];
  assign cfg_wlong = regs[A_CONFIG][1];
  assign ptime     = regs[A_PTIME];
  assign wtime     = regs[A_WTIME];
  assign thr_lo    = {regs[A_TLO_H], regs[A_TLO_L]};
  assign thr_hi    = {regs[A_THI_H], regs[A_THI_L]};
  assign pers      = regs[A_PERS];
  assign ppulse    = regs[A_PPULSE];
  assign ctrl      = regs[A_CONTROL];
  assign poffset   = regs[A_OFFSET];

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && !(wr_stb && dec_cmd) && mode_q == XFER_INC) |=> addr_q == $past(addr_q) + 5'd1); // R4
  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ev && !(wr_stb && dec_cmd) && mode_q == XFER_REPEAT) |=> $stable(addr_q)); // R3
  AST_RSV_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && dec_rsv && !rd_req) |=> ($stable(addr_q) && $stable(mode_q))); // R5
  AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_clr) |-> $past(wr_stb && dec_cmd && dec_type == XFER_SPEC)); // R6
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && dec_set) |=> (addr_q == $past(wr_byte[4:0]) && mode_q == xfer_e'($past(wr_byte[6:5])))); // R1
endmodule

// File: tb/sim_prox_cmd_regif.sv
module sim_prox_cmd_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_start = 1'b0, wr_stb = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [15:0] prox_data = 16'h0000;
  logic st_sat = 1'b0, st_int = 1'b0, st_valid = 1'b0;
  logic [7:0] rd_data, ptime, wtime, pers, ppulse, ctrl, poffset;
  logic int_clr, en_pon, en_pen, en_wen, en_pien, en_sai, cfg_pdl, cfg_wlong;
  logic [15:0] thr_lo, thr_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prox_cmd_regif u0 (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_req(rd_req), .prox_data(prox_data), .st_sat(st_sat), .st_int(st_int),
    .st_valid(st_valid), .rd_data(rd_data), .int_clr(int_clr), .en_pon(en_pon),
    .en_pen(en_pen), .en_wen(en_wen), .en_pien(en_pien), .en_sai(en_sai),
    .cfg_pdl(cfg_pdl), .cfg_wlong(cfg_wlong), .ptime(ptime), .wtime(wtime),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .pers(pers), .ppulse(ppulse), .ctrl(ctrl),
    .poffset(poffset)
  );

  // op: 0 start, 1 write byte, 2 read and compare
  localparam int NV = 50;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h82, 8'h00}, // R1 repeat at PTIME
    {2'd2, 8'h00, 8'hFF}, {2'd2, 8'h00, 8'hFF}, // R7 reset value, R3 same address
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'hA8, 8'h00}, // R4 increment from 0x08
    {2'd1, 8'h11, 8'h00}, {2'd1, 8'h22, 8'h00},
    {2'd1, 8'h33, 8'h00}, {2'd1, 8'h44, 8'h00},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'hA8, 8'h00}, // R4 read burst
    {2'd2, 8'h00, 8'h11}, {2'd2, 8'h00, 8'h22},
    {2'd2, 8'h00, 8'h33}, {2'd2, 8'h00, 8'h44},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h92, 8'h00}, // R8 identity
    {2'd2, 8'h00, 8'h39}, {2'd2, 8'h00, 8'h39},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'hC2, 8'h00}, // R5 reserved type
    {2'd2, 8'h00, 8'h39},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h80, 8'h00}, // enable write
    {2'd1, 8'h6D, 8'h00},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'hBF, 8'h00}, // R4 wrap from 0x1F
    {2'd2, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h6D},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h9E, 8'h00}, // offset register
    {2'd1, 8'h55, 8'h00},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h7F, 8'h00}, // R2 first byte without bit 7
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h9E, 8'h00},
    {2'd2, 8'h00, 8'h7F},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h83, 8'h00}, // R2 later byte with bit 7
    {2'd1, 8'hB6, 8'h00}, {2'd2, 8'h00, 8'hB6},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h92, 8'h00}, // R10 read-only write
    {2'd1, 8'h00, 8'h00}, {2'd2, 8'h00, 8'h39},
    {2'd0, 8'h00, 8'h00}, {2'd1, 8'h85, 8'h00}, // R10 unmapped address
    {2'd1, 8'h77, 8'h00}, {2'd2, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] b);
    @(negedge clk); wr_stb = 1'b1; wr_byte = b;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    v = rd_data;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 ptime", ptime, 8'hFF);
    chk("R7 wtime", wtime, 8'hFF);
    chk("R7 thr_lo", thr_lo, 16'h0000);
    chk("R7 enable bits", {en_pon, en_pen, en_wen, en_pien, en_sai}, 0);
    chk("R7 int_clr", int_clr, 0);
    chk("R7 rd_data", rd_data, 8'h00);
    do_rd(v); // held address 0x00, repeat
    chk("R7 held address reads enable", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: do_start();
        2'd1: do_wr(VEC[i][15:8]);
        default: begin
          do_rd(v);
          if (v !== VEC[i][7:0]) $display("  at vector %0d (R1..R5, R7, R8, R10 table)", i);
          chk("R1 table read", v, VEC[i][7:0]);
        end
      endcase
    end

    // R11 field outputs after the table writes
    chk("R11 enable fields", {en_sai, en_pien, en_wen, en_pen, en_pon}, 5'b11111);
    chk("R11 thr_lo", thr_lo, 16'h2211);
    chk("R11 thr_hi", thr_hi, 16'h4433);
    chk("R11 wtime", wtime, 8'hB6);
    chk("R11 poffset", poffset, 8'h7F);
    do_start(); do_wr(8'h8D); do_wr(8'h03);
    chk("R11 cfg bits 1,1", {cfg_wlong, cfg_pdl}, 2'b11);
    do_wr(8'h01);
    chk("R11 cfg bits 0,1", {cfg_wlong, cfg_pdl}, 2'b01);

    // R8 status packing
    st_sat = 1'b1; st_int = 1'b0; st_valid = 1'b1;
    do_start(); do_wr(8'h93); do_rd(v);
    chk("R8 status sat+valid", v, 8'h42);
    st_sat = 1'b0; st_int = 1'b1; st_valid = 1'b0;
    do_rd(v);
    chk("R8 status int", v, 8'h20);

    // R9 shadowed high byte
    prox_data = 16'h1234;
    do_start(); do_wr(8'hB8); do_rd(v);
    chk("R9 low byte", v, 8'h34);
    prox_data = 16'hABCD;
    do_rd(v);
    chk("R9 shadow high byte", v, 8'h12);

    // R6 special functions
    do_start(); do_wr(8'h92);
    do_start(); do_wr(8'hE5);
    chk("R6 clear strobe 00101", int_clr, 1'b1);
    @(negedge clk);
    chk("R6 strobe one cycle", int_clr, 1'b0);
    do_rd(v);
    chk("R6 address kept", v, 8'h39);
    do_start(); do_wr(8'hE6);
    chk("R6 no strobe 00110", int_clr, 1'b0);
    do_start(); do_wr(8'hE7);
    chk("R6 clear strobe 00111", int_clr, 1'b1);
    @(negedge clk);
    chk("R6 strobe one cycle", int_clr, 1'b0);

    summary();
  end
endmodule